// File: doc/BRIEF.md
# Scaled Clock-Enable Divider

This block turns an incoming clock-enable stream into a slower one. Each time the incoming enable is high on a system clock edge, a down-counter loaded from an 8-bit scale register moves one step. When the counter expires it produces an internal tick and reloads itself. A halving stage then passes on every second tick as a single-cycle output enable. The output enable therefore arrives once for every `2 * N` input enables, where N is the scale value. A scale value of zero stands for a full scale of 256.

Software controls the block through a minimal register port made of a write strobe, write data and read data. Any write, including one that repeats the current value, restarts the period straight away: the counter reloads the new value and the halving stage clears. The read port returns the value most recently written. A second copy of the block can serve a second input enable stream.

Top module: `scaled_clk_gen`

## Requirements
- R1: In the cycle after a synchronous active-low reset, `rd_data` is 0x00 and `scaled_en` is low.
- R2: In the cycle after a write, `rd_data` holds the written byte. It keeps that byte until the next write, whatever the counter is doing.
- R3: When the scale value N is between 1 and 255, `scaled_en` goes high for exactly one cycle after every 2·N-th input enable, counted from the last write. It goes high in the cycle just after the edge that sampled that enable.
- R4: A scale value of 0x00 acts as 256, so a pulse follows every 512 input enables. This also holds after reset when no write has been made.
- R5: A write made part way through a count throws away the progress made so far. The first pulse after the write follows exactly 2·N input enables, where N is the new value.
- R6: A write has priority over a counter expiry that falls in the same cycle. No pulse appears in the next cycle, and counting starts again from the written value.
- R7: `scaled_en` is never high in a cycle unless `src_en` was high on the edge before it, and it is never high in two cycles in a row.
- R8: While `src_en` and `wr_en` are both low, the counter and the halving stage hold their state. The next input enable picks up the count where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_en | input | 1 | Input clock enable to be divided |
| wr_en | input | 1 | Write strobe for the scale register |
| wr_data | input | 8 | Scale value to write (0x00 means 256) |
| rd_data | output | 8 | Last written scale value |
| scaled_en | output | 1 | Divided clock enable, one cycle wide |

## Verification
`rd_data` is registered, so it changes one cycle after the write strobe is sampled. `scaled_en` goes high in the cycle after the edge that samples the 2·N-th input enable, because the counter's tick passes through one output register. The bench changes every input on the falling clock edge and reads the outputs on the next falling edge, so each value is taken from the cycle in which it is due. Between input enables the bench inserts idle cycles and checks that `scaled_en` stays low in them. This confirms that each pulse lands in the single cycle after its enable and in no other.

// File: rtl/scl_pkg.sv
// Package: shared definitions for the scaled clock-enable divider.
// Assumes: the scale register width used across the block is DEF_SCALE_W.
package scl_pkg;
    localparam int DEF_SCALE_W = 8;

    // Phase of the final halving stage.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } half_phase_t;
endpackage

// File: rtl/scl_scale_reg.sv
// Module: holds the software scale value and makes it available to read.
// Assumes: a write may come on any cycle; reset value is zero (full scale).
module scl_scale_reg #(
    parameter int SCALE_W = scl_pkg::DEF_SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SCALE_W-1:0] wr_data,
    output logic [SCALE_W-1:0] scale_q
);
    // Capture the written value; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scale_q <= '0;
        else if (wr_en)
            scale_q <= wr_data;
    end

    AST_RD_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (scale_q == $past(wr_data))); // R2
    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(scale_q)); // R2
endmodule

// File: rtl/scl_down_counter.sv
// Module: down-counter that emits one tick every N source enables.
// Assumes: a scale of zero means 2**SCALE_W; a write reloads at once and
// suppresses any tick in that cycle.
module scl_down_counter #(
    parameter int SCALE_W = scl_pkg::DEF_SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_en,
    input  logic               wr_en,
    input  logic [SCALE_W-1:0] wr_data,
    input  logic [SCALE_W-1:0] scale_q,
    output logic               tick
);
    localparam int CNT_W = SCALE_W + 1;
    localparam logic [CNT_W-1:0] FULL_SCALE = CNT_W'(1) << SCALE_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_cur;
    logic [CNT_W-1:0] reload_new;
    logic             at_last;

    // Expand a stored or written scale value into a count, zero meaning full scale.
    always_comb begin
        reload_cur = (scale_q == '0) ? FULL_SCALE : {1'b0, scale_q};
        reload_new = (wr_data == '0) ? FULL_SCALE : {1'b0, wr_data};
        at_last    = (cnt_q == CNT_W'(1));
    end

    // Tick on the last enable of a count unless a write wins the cycle.
    assign tick = src_en && at_last && !wr_en;

    // Count down on each source enable; reload on expiry or on any write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= FULL_SCALE;
        else if (wr_en)
            cnt_q <= reload_new;
        else if (src_en)
            cnt_q <= at_last ? reload_cur : cnt_q - CNT_W'(1);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= FULL_SCALE)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && !wr_en) |=> $stable(cnt_q)); // R8
    AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !tick); // R6
endmodule

// File: rtl/scl_halver.sv
// Module: final divide-by-two; forwards every second tick as a one-cycle pulse.
// Assumes: clear comes from a register write and restarts the pairing.
module scl_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic pulse
);
    import scl_pkg::*;

    half_phase_t phase_q;

    // Alternate phase on each tick; reset to the first phase on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            phase_q <= PH_FIRST;
        else if (tick)
            phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end

    // Register the pulse for the second tick of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else
            pulse <= tick && !clear && (phase_q == PH_SECOND);
    end

    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick)); // R7
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R7
endmodule

// File: rtl/scaled_clk_gen.sv
// Module: top of the scaled clock-enable divider. Output enable rate is
// the src_en rate divided by twice the scale value (zero means full scale).
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module scaled_clk_gen #(
    parameter int SCALE_W = scl_pkg::DEF_SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_en,
    input  logic               wr_en,
    input  logic [SCALE_W-1:0] wr_data,
    output logic [SCALE_W-1:0] rd_data,
    output logic               scaled_en
);
    logic [SCALE_W-1:0] scale_q;
    logic               tick;

    scl_scale_reg #(.SCALE_W(SCALE_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .scale_q (scale_q)
    );

    scl_down_counter #(.SCALE_W(SCALE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (src_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .scale_q (scale_q),
        .tick    (tick)
    );

    scl_halver u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clear (wr_en),
        .pulse (scaled_en)
    );

    assign rd_data = scale_q;

    AST_PULSE_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        scaled_en |-> $past(src_en)); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !scaled_en); // R6
endmodule

// File: tb/test_scaled_clk_gen.sv
// Directed bench for scaled_clk_gen: one task per scenario.
module test_scaled_clk_gen;
    localparam time HALF = 5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       scaled_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    scaled_clk_gen i_scaled_clk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .scaled_en (scaled_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write a value on one cycle, optionally with src_en high in that cycle.
    task automatic do_write(input logic [7:0] v, input bit with_en);
        wr_en = 1'b1; wr_data = v; src_en = with_en;
        @(negedge clk);
        wr_en = 1'b0; src_en = 1'b0;
    endtask

    // One input enable; returns scaled_en in the following cycle.
    task automatic step_en(output bit p);
        src_en = 1'b1;
        @(negedge clk);
        p = scaled_en;
        src_en = 1'b0;
    endtask

    // Drive enables with idle gaps and compare pulse positions to every 2*n_eff.
    task automatic run_periods(input int n_eff, input int reps, input int gap, input string req);
        int miss = 0;
        int pulses = 0;
        bit p;
        for (int k = 1; k <= 2 * n_eff * reps; k++) begin
            step_en(p);
            if (p) pulses++;
            if (p != ((k % (2 * n_eff)) == 0)) miss++;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (scaled_en) miss++; // R7: no pulse without a preceding enable
            end
        end
        check(miss == 0, req, miss, 0);
        check(pulses == reps, req, pulses, reps);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rd_data == 8'h00, "R1", rd_data, 0);
        check(scaled_en == 1'b0, "R1", scaled_en, 0);
    endtask

    task automatic t_default_full;
        run_periods(256, 2, 0, "R4");
    endtask

    task automatic t_scale(input logic [7:0] v, input int gap, input string req);
        int n_eff = (v == 0) ? 256 : int'(v);
        do_write(v, 1'b0);
        check(rd_data == v, "R2", rd_data, v);
        run_periods(n_eff, 2, gap, req);
        check(rd_data == v, "R2", rd_data, v);
    endtask

    task automatic t_midcount;
        bit p;
        int seen = 0;
        do_write(8'd4, 1'b0);
        for (int k = 0; k < 5; k++) begin
            step_en(p);
            if (p) seen++;
        end
        check(seen == 0, "R5", seen, 0);
        do_write(8'd3, 1'b1);
        check(rd_data == 8'd3, "R2", rd_data, 3);
        run_periods(3, 1, 1, "R5");
    endtask

    task automatic t_collision;
        bit p;
        do_write(8'd1, 1'b0);
        step_en(p);
        check(p == 1'b0, "R6", p, 0);
        do_write(8'd2, 1'b1); // would be the pulse-making expiry without the write
        check(scaled_en == 1'b0, "R6", scaled_en, 0);
        run_periods(2, 1, 0, "R6");
    endtask

    task automatic t_idle_hold;
        bit p;
        int seen = 0;
        do_write(8'd1, 1'b0);
        step_en(p);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (scaled_en) seen++;
        end
        check(seen == 0, "R8", seen, 0);
        step_en(p);
        check(p == 1'b1, "R8", p, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_default_full();
        t_scale(8'd1, 1, "R3");
        t_scale(8'd2, 2, "R3");
        t_scale(8'd255, 0, "R3");
        t_scale(8'd0, 0, "R4");
        t_midcount();
        t_collision();
        t_idle_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule